// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

This block is the control unit of a small word-addressed processor. It steps the processor through fetch, execute and interrupt cycles and issues one-clock control strobes to a datapath that it does not contain: the program counter, memory address and data registers, instruction register, result register R1, a return-address stack and the memory. It looks at the opcode held in the instruction register, the zero flag of R1, an interrupt request and a memory completion signal. The cycle in progress is held in a two-bit flag pair. A binary step counter, decoded to one-hot, picks the strobes for each step inside a cycle.

After reset the controller stays idle until `start` is pulsed. From then on it runs instructions until it executes a halt. Every instruction is one word: the top three bits are the opcode and the low bits are an address. The instruction set is add-from-memory into R1, unconditional jump, jump-if-zero, return from interrupt handler and halt. Memory reads wait as long as memory needs. An interrupt is taken only between instructions and only while interrupts are enabled.

Top module: `hwc_ctl`

## Requirements
- R1: After reset the cycle flags read fetch, the step is 0, and every strobe, `mem_rd`, `busy` and `done` are low. They stay low until `start` is sampled high.
- R2: The cycle flag pair {F,E} takes only the values 2'b10 (fetch), 2'b01 (execute) and 2'b11 (interrupt). The value 2'b00 is never held after reset.
- R3: A fetch runs four steps in a fixed order. The first pulses `mar_ld_pc` with `mem_rd` raised. The read step pulses `mdr_ld` and `pc_inc` together. The next pulses `ir_ld`. The last issues no strobe and moves to execute. `pc_inc` pulses exactly once per fetched instruction.
- R4: Each strobe appears in the clock after the edge that performs its step. A read step raises `mem_rd` and holds it, with the step counter frozen, until `mem_ready` is sampled high. The completion strobes follow in the next clock. A read that is ready at once takes one clock.
- R5: Opcode 3'b000 (add) executes in three steps: `mar_ld_ir`, then a memory read that pulses `mdr_ld`, then `r1_add`.
- R6: Opcode 3'b001 (jump) pulses `pc_ld_ir` in its single execute step.
- R7: Opcode 3'b010 (jump-if-zero) pulses `pc_ld_ir` only when `zero` is high. Otherwise it leaves the PC strobes idle.
- R8: At the end of every execute except halt, if `irq` is high and interrupts are enabled, the controller enters the interrupt cycle: `pc_push`, then `pc_ld_vec` in the next clock, then fetch. Entering the interrupt cycle disables interrupts.
- R9: Opcode 3'b011 (return) pulses `pc_pop` and re-enables interrupts. The re-enable takes effect from the next instruction boundary, so the return itself never re-enters the handler.
- R10: Opcode 3'b100 (halt) pulses `done` for one clock and drops `busy` in that same clock. No strobe or read follows until the next `start`, which resumes fetching from the current PC. `start` raises `busy` and enables interrupts.
- R11: Strobes are registered single-clock pulses. Exactly one step is active at a time. At most one PC-changing strobe is active in any clock.
- R12: Opcodes 3'b101 to 3'b111 execute in one step with no strobe and then return to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin running from the current PC |
| opcode | input | 3 | Opcode field of the instruction register |
| zero | input | 1 | R1 equals zero |
| irq | input | 1 | Interrupt request, level |
| mem_ready | input | 1 | Memory read completion |
| mar_ld_pc | output | 1 | Load MAR from PC |
| mar_ld_ir | output | 1 | Load MAR from the instruction address field |
| mdr_ld | output | 1 | Load MDR from memory |
| pc_inc | output | 1 | Increment PC |
| ir_ld | output | 1 | Load IR from MDR |
| r1_add | output | 1 | R1 <= R1 + MDR |
| pc_ld_ir | output | 1 | Load PC from the instruction address field |
| pc_push | output | 1 | Push PC onto the return stack |
| pc_ld_vec | output | 1 | Load PC with the handler start address |
| pc_pop | output | 1 | Pop PC from the return stack |
| mem_rd | output | 1 | Memory read request, held until completion |
| busy | output | 1 | Controller running |
| done | output | 1 | One-clock pulse when a halt completes |

## Verification
A wrong cycle flag or a step that does not advance shows as a strobe out of order, or as a missing strobe, in the clock right after the faulty edge. The bench therefore compares the strobe pattern clock by clock through a whole fetch, and counts clocks from `start` to `done` under several memory latencies. A wrong opcode decode, a wrong zero-flag test or a wrong interrupt-enable state shows only later, as a wrong final R1 or PC or a wrong push count in the behavioural datapath. So each program is built to make every such fault change those end values.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  // Cycle flag pair {F,E}
  localparam logic [1:0] CYC_FETCH = 2'b10;
  localparam logic [1:0] CYC_EXEC  = 2'b01;
  localparam logic [1:0] CYC_INTR  = 2'b11;

  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_JMP  = 3'd1;
  localparam logic [OP_W-1:0] OP_JZ   = 3'd2;
  localparam logic [OP_W-1:0] OP_RET  = 3'd3;
  localparam logic [OP_W-1:0] OP_HALT = 3'd4;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mdr;
    logic pc_inc;
    logic ir;
    logic r1_add;
    logic pc_jmp;
    logic pc_push;
    logic pc_vec;
    logic pc_pop;
  } strobe_t;
endpackage

// File: rtl/hwc_step_ctr.sv
module hwc_step_ctr #(
  parameter int STEP_W = 2,
  localparam int NSTEP = 1 << STEP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             adv,
  input  logic             clr,
  output logic [NSTEP-1:0] step_oh
);
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else if (en) begin
      if (clr)      step <= '0;
      else if (adv) step <= step + 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NSTEP; i++) begin : g_dec
      assign step_oh[i] = (step == STEP_W'(i));
    end
  endgenerate
endmodule

// File: rtl/hwc_cyc_reg.sv
module hwc_cyc_reg
  import hwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       finish,
  input  logic [1:0] next_cyc,
  input  logic       halt,
  input  logic       set_ie,
  input  logic       clr_ie,
  output logic [1:0] cyc,
  output logic       running,
  output logic       ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc     <= CYC_FETCH;
      running <= 1'b0;
      ie      <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        ie      <= 1'b1;
      end
    end else begin
      if (finish) cyc <= next_cyc;
      if (halt)   running <= 1'b0;
      if (clr_ie)      ie <= 1'b0;
      else if (set_ie) ie <= 1'b1;
    end
  end
endmodule

// File: rtl/hwc_decode.sv
module hwc_decode
  import hwc_pkg::*;
#(
  parameter int NSTEP = 4
) (
  input  logic [1:0]      cyc,
  input  logic [NSTEP-1:0] step_oh,
  input  logic [OP_W-1:0] opcode,
  input  logic            zero,
  input  logic            mem_ready,
  input  logic            irq,
  input  logic            ie,
  output strobe_t         stb,
  output logic            adv,
  output logic            finish,
  output logic [1:0]      next_cyc,
  output logic            halt,
  output logic            set_ie,
  output logic            clr_ie,
  output logic            rd_next
);
  logic [1:0] after_exec;
  assign after_exec = (irq && ie) ? CYC_INTR : CYC_FETCH;

  always_comb begin
    stb      = '0;
    adv      = 1'b0;
    finish   = 1'b0;
    next_cyc = CYC_FETCH;
    halt     = 1'b0;
    set_ie   = 1'b0;
    rd_next  = 1'b0;
    case (cyc)
      CYC_FETCH: begin
        if (step_oh[0]) begin
          stb.mar_pc = 1'b1; adv = 1'b1; rd_next = 1'b1;
        end else if (step_oh[1]) begin
          if (mem_ready) begin
            stb.mdr = 1'b1; stb.pc_inc = 1'b1; adv = 1'b1;
          end else rd_next = 1'b1;
        end else if (step_oh[2]) begin
          stb.ir = 1'b1; adv = 1'b1;
        end else begin
          finish = 1'b1; next_cyc = CYC_EXEC;
        end
      end
      CYC_EXEC: begin
        case (opcode)
          OP_ADD: begin
            if (step_oh[0]) begin
              stb.mar_ir = 1'b1; adv = 1'b1; rd_next = 1'b1;
            end else if (step_oh[1]) begin
              if (mem_ready) begin
                stb.mdr = 1'b1; adv = 1'b1;
              end else rd_next = 1'b1;
            end else if (step_oh[2]) begin
              stb.r1_add = 1'b1; finish = 1'b1; next_cyc = after_exec;
            end else begin
              finish = 1'b1;
            end
          end
          OP_JMP: begin
            stb.pc_jmp = 1'b1; finish = 1'b1; next_cyc = after_exec;
          end
          OP_JZ: begin
            stb.pc_jmp = zero; finish = 1'b1; next_cyc = after_exec;
          end
          OP_RET: begin
            stb.pc_pop = 1'b1; set_ie = 1'b1; finish = 1'b1; next_cyc = after_exec;
          end
          OP_HALT: begin
            halt = 1'b1; finish = 1'b1;
          end
          default: begin
            finish = 1'b1; next_cyc = after_exec;
          end
        endcase
      end
      CYC_INTR: begin
        if (step_oh[0]) begin
          stb.pc_push = 1'b1; adv = 1'b1;
        end else begin
          stb.pc_vec = 1'b1; finish = 1'b1;
        end
      end
      default: finish = 1'b1;
    endcase
  end

  assign clr_ie = finish && (next_cyc == CYC_INTR);
endmodule

// File: rtl/hwc_ctl.sv
module hwc_ctl
  import hwc_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  input  logic            zero,
  input  logic            irq,
  input  logic            mem_ready,
  output logic            mar_ld_pc,
  output logic            mar_ld_ir,
  output logic            mdr_ld,
  output logic            pc_inc,
  output logic            ir_ld,
  output logic            r1_add,
  output logic            pc_ld_ir,
  output logic            pc_push,
  output logic            pc_ld_vec,
  output logic            pc_pop,
  output logic            mem_rd,
  output logic            busy,
  output logic            done
);
  localparam int NSTEP = 1 << STEP_W;

  logic [1:0]       cyc;
  logic             running, ie;
  logic [NSTEP-1:0] step_oh;
  strobe_t          stb, stb_q;
  logic             adv, finish, halt, set_ie, clr_ie, rd_next;
  logic [1:0]       next_cyc;
  logic             mem_rd_q, done_q;

  hwc_cyc_reg u_cyc (
    .clk(clk), .rst(rst), .start(start), .finish(finish), .next_cyc(next_cyc),
    .halt(halt), .set_ie(set_ie), .clr_ie(clr_ie),
    .cyc(cyc), .running(running), .ie(ie)
  );

  hwc_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .en(running), .adv(adv), .clr(finish), .step_oh(step_oh)
  );

  hwc_decode #(.NSTEP(NSTEP)) u_dec (
    .cyc(cyc), .step_oh(step_oh), .opcode(opcode), .zero(zero),
    .mem_ready(mem_ready), .irq(irq), .ie(ie),
    .stb(stb), .adv(adv), .finish(finish), .next_cyc(next_cyc), .halt(halt),
    .set_ie(set_ie), .clr_ie(clr_ie), .rd_next(rd_next)
  );

  // Registered strobes: each step's strobes appear in the following clock
  always_ff @(posedge clk) begin
    if (rst || !running) begin
      stb_q    <= '0;
      mem_rd_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      stb_q    <= stb;
      mem_rd_q <= rd_next;
      done_q   <= halt;
    end
  end

  assign mar_ld_pc = stb_q.mar_pc;
  assign mar_ld_ir = stb_q.mar_ir;
  assign mdr_ld    = stb_q.mdr;
  assign pc_inc    = stb_q.pc_inc;
  assign ir_ld     = stb_q.ir;
  assign r1_add    = stb_q.r1_add;
  assign pc_ld_ir  = stb_q.pc_jmp;
  assign pc_push   = stb_q.pc_push;
  assign pc_ld_vec = stb_q.pc_vec;
  assign pc_pop    = stb_q.pc_pop;
  assign mem_rd    = mem_rd_q;
  assign busy      = running;
  assign done      = done_q;
endmodule

// File: rtl/hwc_ctl_chk.sv
module hwc_ctl_chk #(
  parameter int NSTEP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cyc,
  input logic [NSTEP-1:0] step_oh,
  input logic             mar_ld_pc,
  input logic             mar_ld_ir,
  input logic             mdr_ld,
  input logic             pc_inc,
  input logic             ir_ld,
  input logic             r1_add,
  input logic             pc_ld_ir,
  input logic             pc_push,
  input logic             pc_ld_vec,
  input logic             pc_pop,
  input logic             mem_rd,
  input logic             mem_ready,
  input logic             busy,
  input logic             done
);
  assert_cyc_legal_R2: assert property (@(posedge clk) disable iff (rst)
    cyc != 2'b00);

  assert_step_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(step_oh) == 1);

  assert_pc_single_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({pc_inc, pc_ld_ir, pc_ld_vec, pc_pop}) <= 1);

  assert_inc_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> !pc_inc);

  assert_irld_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> !ir_ld);

  assert_inc_with_mdr_R3: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> mdr_ld);

  assert_mar_read_R3: assert property (@(posedge clk) disable iff (rst)
    mar_ld_pc |-> mem_rd);

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(step_oh)));

  assert_push_vec_R8: assert property (@(posedge clk) disable iff (rst)
    pc_push |=> pc_ld_vec);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd || mar_ld_pc || mar_ld_ir || mdr_ld || pc_inc || ir_ld ||
                r1_add || pc_ld_ir || pc_push || pc_ld_vec || pc_pop));
endmodule

bind hwc_ctl hwc_ctl_chk #(.NSTEP(NSTEP)) u_chk (
  .clk(clk), .rst(rst), .cyc(cyc), .step_oh(step_oh),
  .mar_ld_pc(mar_ld_pc), .mar_ld_ir(mar_ld_ir), .mdr_ld(mdr_ld), .pc_inc(pc_inc),
  .ir_ld(ir_ld), .r1_add(r1_add), .pc_ld_ir(pc_ld_ir), .pc_push(pc_push),
  .pc_ld_vec(pc_ld_vec), .pc_pop(pc_pop), .mem_rd(mem_rd), .mem_ready(mem_ready),
  .busy(busy), .done(done)
);

// File: tb/sim_hwc_ctl.sv
`timescale 1ns/1ps
module sim_hwc_ctl;
  localparam int AW = 5;
  localparam logic [AW-1:0] HANDLER = 5'd16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic irq = 1'b0;
  logic mem_ready = 1'b0;
  logic [2:0] opcode;
  logic zero;
  logic mar_ld_pc, mar_ld_ir, mdr_ld, pc_inc, ir_ld, r1_add;
  logic pc_ld_ir, pc_push, pc_ld_vec, pc_pop, mem_rd, busy, done;

  int n_tests = 0;
  int n_fail = 0;
  int lat = 0;
  int rd_cnt = 0;

  // Behavioural datapath
  logic [7:0]    mem [32];
  logic [AW-1:0] PC, MAR;
  logic [7:0]    MDR, IR, R1;
  logic [AW-1:0] stk [4];
  logic [1:0]    sp;
  int n_inc, n_push, n_pop;

  always #5 clk = ~clk;

  hwc_ctl u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .zero(zero), .irq(irq),
    .mem_ready(mem_ready), .mar_ld_pc(mar_ld_pc), .mar_ld_ir(mar_ld_ir), .mdr_ld(mdr_ld),
    .pc_inc(pc_inc), .ir_ld(ir_ld), .r1_add(r1_add), .pc_ld_ir(pc_ld_ir),
    .pc_push(pc_push), .pc_ld_vec(pc_ld_vec), .pc_pop(pc_pop), .mem_rd(mem_rd),
    .busy(busy), .done(done)
  );

  assign opcode = IR[7:5];
  assign zero   = (R1 == 8'd0);

  always @(posedge clk) begin
    if (rst) begin
      PC <= '0; MAR <= '0; MDR <= '0; IR <= '0; R1 <= '0; sp <= '0;
      n_inc <= 0; n_push <= 0; n_pop <= 0;
    end else begin
      if (mar_ld_pc) MAR <= PC;
      if (mar_ld_ir) MAR <= IR[AW-1:0];
      if (mdr_ld)    MDR <= mem[MAR];
      if (ir_ld)     IR <= MDR;
      if (r1_add)    R1 <= R1 + MDR;
      if (pc_inc)    begin PC <= PC + 1'b1; n_inc <= n_inc + 1; end
      if (pc_ld_ir)  PC <= IR[AW-1:0];
      if (pc_push)   begin stk[sp] <= PC; sp <= sp + 1'b1; n_push <= n_push + 1; end
      if (pc_ld_vec) PC <= HANDLER;
      if (pc_pop)    begin PC <= stk[sp - 1'b1]; sp <= sp - 1'b1; n_pop <= n_pop + 1; end
    end
  end

  // Memory with programmable read latency
  always @(negedge clk) begin
    if (rst || !mem_rd) begin
      rd_cnt <= 0; mem_ready <= 1'b0;
    end else begin
      mem_ready <= (rd_cnt >= lat);
      rd_cnt <= rd_cnt + 1;
    end
  end

  function automatic logic [7:0] w(input logic [2:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    for (int i = 0; i < 32; i++) mem[i] = 8'd0;
    irq = 1'b0; start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic run_prog(input int l, output int cycles);
    bit got;
    lat = l;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    cycles = 0; got = 0;
    while (!got && cycles < 3000) begin
      @(posedge clk); cycles++;
      @(negedge clk);
      if (pc_pop) irq = 1'b0;
      if (done) got = 1;
    end
    if (!got) chk("run watchdog", 0, 1);
  endtask

  function automatic int any_act();
    return int'({mar_ld_pc, mar_ld_ir, mdr_ld, pc_inc, ir_ld, r1_add, pc_ld_ir,
                 pc_push, pc_ld_vec, pc_pop, mem_rd, busy, done} != 13'd0);
  endfunction

  task automatic t_reset();
    int seen;
    do_reset();
    chk("R1 reset outputs", any_act(), 0);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seen += any_act();
    end
    chk("R1 idle without start", seen, 0);
  endtask

  task automatic t_fetch_order();
    logic [5:0] exp_seq [6];
    logic [5:0] got;
    exp_seq[0] = 6'b110000; exp_seq[1] = 6'b010000; exp_seq[2] = 6'b001100;
    exp_seq[3] = 6'b000010; exp_seq[4] = 6'b000000; exp_seq[5] = 6'b000001;
    do_reset();
    mem[0] = w(3'd4, 5'd0);
    lat = 1;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(posedge clk); @(negedge clk);
      got = {mar_ld_pc, mem_rd, mdr_ld, pc_inc, ir_ld, done};
      chk($sformatf("R3 R4 R11 fetch strobes clock %0d", c + 1), int'(got), int'(exp_seq[c]));
    end
    chk("R10 busy low at done", int'(busy), 0);
    chk("R3 PC after one fetch", int'(PC), 1);
  endtask

  task automatic t_add_timing();
    int cyc;
    do_reset();
    mem[0] = w(3'd0, 5'd20); mem[1] = w(3'd4, 5'd0); mem[20] = 8'd37;
    run_prog(0, cyc);
    chk("R5 add result", int'(R1), 37);
    chk("R4 cycles latency 0", cyc, 12);
    chk("R3 one increment per fetch", n_inc, 2);
    do_reset();
    mem[0] = w(3'd0, 5'd20); mem[1] = w(3'd4, 5'd0); mem[20] = 8'd37;
    run_prog(3, cyc);
    chk("R5 add result latency 3", int'(R1), 37);
    chk("R4 cycles latency 3", cyc, 21);
  endtask

  task automatic t_jmp();
    int cyc;
    do_reset();
    mem[0] = w(3'd1, 5'd4); mem[1] = w(3'd0, 5'd20);
    mem[4] = w(3'd0, 5'd21); mem[5] = w(3'd4, 5'd0);
    mem[20] = 8'd9; mem[21] = 8'd14;
    run_prog(1, cyc);
    chk("R6 jump skips add", int'(R1), 14);
    chk("R6 final PC", int'(PC), 6);
  endtask

  task automatic t_jz();
    int cyc;
    do_reset();
    mem[0] = w(3'd0, 5'd20); mem[1] = w(3'd2, 5'd5);
    mem[2] = w(3'd0, 5'd21); mem[3] = w(3'd2, 5'd6);
    mem[4] = w(3'd4, 5'd0);
    mem[6] = w(3'd0, 5'd22); mem[7] = w(3'd4, 5'd0);
    mem[20] = 8'd5; mem[21] = 8'd251; mem[22] = 8'd7;
    run_prog(0, cyc);
    chk("R7 jz both ways result", int'(R1), 7);
    chk("R7 final PC", int'(PC), 8);
    chk("R7 fetch count", n_inc, 6);
  endtask

  task automatic t_irq();
    int cyc;
    do_reset();
    mem[0] = w(3'd0, 5'd20); mem[1] = w(3'd0, 5'd21); mem[2] = w(3'd4, 5'd0);
    mem[16] = w(3'd0, 5'd22); mem[17] = w(3'd0, 5'd23); mem[18] = w(3'd3, 5'd0);
    mem[20] = 8'd3; mem[21] = 8'd40; mem[22] = 8'd5; mem[23] = 8'd11;
    irq = 1'b1;
    run_prog(1, cyc);
    chk("R8 R9 result with handler", int'(R1), 59);
    chk("R8 single entry while disabled", n_push, 1);
    chk("R8 saved PC", int'(stk[0]), 1);
    chk("R9 return pops once", n_pop, 1);
    chk("R9 final PC", int'(PC), 3);
  endtask

  task automatic t_nop_restart();
    int cyc, seen;
    do_reset();
    mem[0] = w(3'd5, 5'd20); mem[1] = w(3'd7, 5'd21); mem[2] = w(3'd4, 5'd0);
    mem[3] = w(3'd4, 5'd0);
    mem[20] = 8'd9; mem[21] = 8'd9;
    run_prog(0, cyc);
    chk("R12 unused opcodes no add", int'(R1), 0);
    chk("R12 cycles", cyc, 15);
    chk("R12 final PC", int'(PC), 3);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      seen += any_act();
    end
    chk("R10 quiet after halt", seen, 0);
    run_prog(0, cyc);
    chk("R10 restart from PC", int'(PC), 4);
    chk("R10 restart cycles", cyc, 5);
  endtask

  initial begin
    #1ms;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fetch_order();
    t_add_timing();
    t_jmp();
    t_jz();
    t_irq();
    t_nop_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule